// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block sits beside a DRAM controller and measures how it behaves. A set of
counters (four by default) advances on event strobes chosen by software. Each
counter has its own selection register. The first counter is special: it always
advances once per clock and sets the measurement window. When this window
counter steps past its all-ones value, every counter freezes and a level
interrupt is raised. The other counters roll over to zero with no side effect.

Two selection codes do not use the strobe bus. They count read or write address
transactions whose ID passes one masked-compare filter, which every counter
shares. A small register port with single-cycle writes and combinational reads
holds the enable, the clear, the filter, the selections and the counter values.

Top module: `mc_perf_monitor`

## Requirements
- R1: After reset all counters read zero, the interrupt is low, counting is disabled and the filter and selection registers read zero.
- R2: Counter 0 advances by one on every clock edge at which counting is enabled and the unit is not locked, whatever its selection register holds.
- R3: When counter 0 steps from all-ones it wraps to zero and the unit locks, with the interrupt high from the next cycle. On that final edge the other counters still count their own events.
- R4: While locked, every counter holds its value and stays readable, the interrupt stays high and the lock bit reads one.
- R5: Counters 1 to 3 wrap from all-ones to zero, never lock the unit and never raise the interrupt.
- R6: Writing 1 to the clear bit zeroes every counter, releases the lock and drops the interrupt. On the same edge it wins over any counting or timer wrap.
- R7: A selection code from 0x00 up to the number of strobes minus one (0x3F by default) counts the edges at which that strobe bit is high.
- R8: Code 0x41 counts edges with a valid read transaction whose ID satisfies ((id XOR filter_id) AND filter_mask) == 0. Code 0x42 does the same for write transactions, using the same filter.
- R9: Any other selection code (0x40, 0x43 to 0xFF, or a strobe index past the last strobe) never advances its counter.
- R10: A write to a selection register applies from the next edge. The edge of the write still uses the old code, and the counter keeps its value.
- R11: Register map, word addresses: 0x0 control (bit0 enable, bit1 clear which reads 0, bit2 lock which is read-only); 0x1 filter (bits[15:0] ID, bits[31:16] mask); 0x4+n selection of counter n in bits[7:0]; 0x8+n counter n, read-only. Writes to read-only or unused addresses change nothing, and unused addresses read zero.
- R12: With the enable bit at 0, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| evt_strobe | input | NUM_EVT | One-cycle event strobes from the controller |
| rd_txn_vld | input | 1 | Read address transaction valid this cycle |
| rd_txn_id | input | ID_W | Read transaction ID |
| wr_txn_vld | input | 1 | Write address transaction valid this cycle |
| wr_txn_id | input | ID_W | Write transaction ID |
| irq_o | output | 1 | Level interrupt, high while locked |

## Verification
Two events can land on one edge: the window counter wrapping and a software clear. The bench runs the window counter to all-ones and then issues the clear on exactly the edge where the wrap would occur. It then expects the counter at zero with no lock and no interrupt, followed by an increment to one on the next edge. A selection write can also meet a live strobe on the same edge. The bench drives both the old and the new strobe on that edge and expects exactly one increment, counted under the old code.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int REG_AW = 4;
   localparam int REG_DW = 32;

   localparam logic [REG_AW-1:0] A_CTRL = 4'h0;
   localparam logic [REG_AW-1:0] A_FILT = 4'h1;
   localparam logic [REG_AW-1:0] A_CFG0 = 4'h4;
   localparam logic [REG_AW-1:0] A_CNT0 = 4'h8;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_CLR_BIT  = 1;
   localparam int CTRL_LOCK_BIT = 2;
   localparam int FILT_MASK_LSB = 16;

   localparam logic [7:0] SEL_RD_FILT = 8'h41;
   localparam logic [7:0] SEL_WR_FILT = 8'h42;
endpackage

// File: rtl/pmu_id_filter.sv
module pmu_id_filter #(
   parameter int ID_W = 16
) (
   input  logic [ID_W-1:0] txn_id,
   input  logic [ID_W-1:0] ref_id,
   input  logic [ID_W-1:0] care,
   output logic            pass
);
   // only bits with care=1 take part in the compare
   assign pass = ((txn_id ^ ref_id) & care) == '0;
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
   import pmu_pkg::*;
#(
   parameter int NUM_EVT = 64,
   parameter int SEL_W   = 8
) (
   input  logic [SEL_W-1:0]   code,
   input  logic [NUM_EVT-1:0] evt,
   input  logic               rd_vld,
   input  logic               rd_pass,
   input  logic               wr_vld,
   input  logic               wr_pass,
   output logic               hit
);
   localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
   localparam logic [SEL_W-1:0] EVT_LIMIT = SEL_W'(NUM_EVT);
   localparam logic [SEL_W-1:0] CODE_RD   = SEL_W'(SEL_RD_FILT);
   localparam logic [SEL_W-1:0] CODE_WR   = SEL_W'(SEL_WR_FILT);

   always_comb begin
      hit = 1'b0;
      if (code < EVT_LIMIT)
         hit = evt[code[IDX_W-1:0]];
      else if (code == CODE_RD)
         hit = rd_vld & rd_pass;
      else if (code == CODE_WR)
         hit = wr_vld & wr_pass;
   end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             step,
   output logic [CNT_W-1:0] value,
   output logic             wrap
);
   assign wrap = run & step & (value == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= '0;
      else if (clr)
         value <= '0;
      else if (run && step)
         value <= value + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && !clr) |=> (value == $past(value) + 1'b1)); // R2
   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !clr) |=> (value == '0)); // R5
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(value)); // R12
endmodule

// File: rtl/mc_perf_monitor.sv
module mc_perf_monitor
   import pmu_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int NUM_EVT = 64,
   parameter int SEL_W   = 8,
   parameter int ID_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [3:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_EVT-1:0] evt_strobe,
   input  logic               rd_txn_vld,
   input  logic [ID_W-1:0]    rd_txn_id,
   input  logic               wr_txn_vld,
   input  logic [ID_W-1:0]    wr_txn_id,
   output logic               irq_o
);
   if (NUM_CNT < 2 || NUM_CNT > 4) begin : g_bad_cnt
      $error("NUM_CNT must be 2..4");
   end
   if (CNT_W < 2 || CNT_W > REG_DW) begin : g_bad_width
      $error("CNT_W must be 2..32");
   end
   if (NUM_EVT < 2 || NUM_EVT > 64) begin : g_bad_evt
      $error("NUM_EVT must be 2..64");
   end
   if (SEL_W < 7 || SEL_W > 8) begin : g_bad_sel
      $error("SEL_W must be 7 or 8");
   end
   if (ID_W < 1 || ID_W > 16) begin : g_bad_id
      $error("ID_W must be 1..16");
   end

   logic             en_q;
   logic             lock_q;
   logic [ID_W-1:0]  flt_id_q;
   logic [ID_W-1:0]  flt_mask_q;
   logic [SEL_W-1:0] cfg_q   [NUM_CNT];
   logic [CNT_W-1:0] cnt_val [NUM_CNT];
   logic [NUM_CNT-1:0] cnt_wrap;
   logic             clr_p;
   logic             run;
   logic             rd_pass;
   logic             wr_pass;
   logic             unused_wdata_bits;

   assign unused_wdata_bits = ^reg_wdata;
   assign clr_p = reg_we && (reg_addr == A_CTRL) && reg_wdata[CTRL_CLR_BIT];
   assign run   = en_q && !lock_q;
   assign irq_o = lock_q;

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         flt_id_q   <= '0;
         flt_mask_q <= '0;
         for (int k = 0; k < NUM_CNT; k++) cfg_q[k] <= '0;
      end else if (reg_we) begin
         if (reg_addr == A_CTRL)
            en_q <= reg_wdata[CTRL_EN_BIT];
         if (reg_addr == A_FILT) begin
            flt_id_q   <= reg_wdata[ID_W-1:0];
            flt_mask_q <= reg_wdata[FILT_MASK_LSB +: ID_W];
         end
         for (int k = 0; k < NUM_CNT; k++)
            if (reg_addr == REG_AW'(int'(A_CFG0) + k))
               cfg_q[k] <= reg_wdata[SEL_W-1:0];
      end
   end

   // window lock: clear beats a same-edge timer wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (clr_p)
         lock_q <= 1'b0;
      else if (cnt_wrap[0])
         lock_q <= 1'b1;
   end

   pmu_id_filter #(.ID_W(ID_W)) u_rd_flt (
      .txn_id(rd_txn_id), .ref_id(flt_id_q), .care(flt_mask_q), .pass(rd_pass));
   pmu_id_filter #(.ID_W(ID_W)) u_wr_flt (
      .txn_id(wr_txn_id), .ref_id(flt_id_q), .care(flt_mask_q), .pass(wr_pass));

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic hit;
      if (i == 0) begin : g_timer
         assign hit = 1'b1;
      end else begin : g_event
         pmu_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
            .code(cfg_q[i]), .evt(evt_strobe),
            .rd_vld(rd_txn_vld), .rd_pass(rd_pass),
            .wr_vld(wr_txn_vld), .wr_pass(wr_pass),
            .hit(hit));
      end

      pmu_counter #(.CNT_W(CNT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .clr(clr_p), .run(run),
         .step(hit), .value(cnt_val[i]), .wrap(cnt_wrap[i]));

      AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
         (lock_q && !clr_p) |=> $stable(cnt_val[i])); // R4
   end

   // combinational read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CTRL) begin
         reg_rdata[CTRL_EN_BIT]   = en_q;
         reg_rdata[CTRL_LOCK_BIT] = lock_q;
      end
      if (reg_addr == A_FILT) begin
         reg_rdata[ID_W-1:0]              = flt_id_q;
         reg_rdata[FILT_MASK_LSB +: ID_W] = flt_mask_q;
      end
      for (int k = 0; k < NUM_CNT; k++) begin
         if (reg_addr == REG_AW'(int'(A_CFG0) + k))
            reg_rdata[SEL_W-1:0] = cfg_q[k];
         if (reg_addr == REG_AW'(int'(A_CNT0) + k))
            reg_rdata[CNT_W-1:0] = cnt_val[k];
      end
   end

   AST_TMR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wrap[0] && !clr_p) |=> irq_o); // R3
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(cnt_wrap[0])); // R5
   AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_p |=> (!irq_o && cnt_val[0] == '0)); // R6
endmodule

// File: tb/sim_mc_perf_monitor.sv
`timescale 1ns/100ps
module sim_mc_perf_monitor;
   localparam int CW = 8;
   localparam int NE = 64;
   localparam int IW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NE-1:0] evt_strobe = '0;
   logic          rd_txn_vld = 1'b0;
   logic [IW-1:0] rd_txn_id = '0;
   logic          wr_txn_vld = 1'b0;
   logic [IW-1:0] wr_txn_id = '0;
   logic          irq_o;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   mc_perf_monitor #(.NUM_CNT(4), .CNT_W(CW), .NUM_EVT(NE), .SEL_W(8), .ID_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe),
      .rd_txn_vld(rd_txn_vld), .rd_txn_id(rd_txn_id),
      .wr_txn_vld(wr_txn_vld), .wr_txn_id(wr_txn_id), .irq_o(irq_o));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic quiet();
      evt_strobe = '0; rd_txn_vld = 1'b0; wr_txn_vld = 1'b0;
   endtask

   function automatic logic pat(int k, int c);
      return ((k * 3 + c * 5) % 7) < 3;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int exp_n;
      int exp_r;
      int exp_w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and R11 map
      for (int a = 0; a < 16; a++) chk_reg("R1 reset read", 4'(a), 32'h0);
      chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);

      // R7 / R9 sweep of all strobe codes on counter 1
      for (int code = 0; code < 69; code++) begin
         int sel;
         sel = (code < 64) ? code :
               (code == 64) ? 8'h40 : (code == 65) ? 8'h43 :
               (code == 66) ? 8'h7F : (code == 67) ? 8'h80 : 8'hFF;
         quiet();
         wr(4'h0, 32'h2);
         wr(4'h5, 32'(sel));
         wr(4'h0, 32'h1);
         exp_n = 0;
         for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < NE; k++) evt_strobe[k] = (code < 64) ? pat(k, c) : 1'b1;
            rd_txn_vld = 1'b1; wr_txn_vld = 1'b1;
            if (code < 64 && pat(code, c)) exp_n++;
            tick();
         end
         quiet();
         wr(4'h0, 32'h0);
         if (code < 64) chk_reg($sformatf("R7 strobe code %0d", sel), 4'h9, 32'(exp_n));
         else           chk_reg($sformatf("R9 unknown code 0x%0h", sel), 4'h9, 32'h0);
      end

      // R8 shared ID filter, R2 timer count, R11 filter readback
      wr(4'h1, 32'h00F0_0050);
      chk_reg("R11 filter readback", 4'h1, 32'h00F0_0050);
      wr(4'h5, 32'h3F);
      wr(4'h6, 32'h41);
      wr(4'h7, 32'h42);
      wr(4'h4, 32'h42);
      quiet();
      wr(4'h0, 32'h3);
      exp_n = 0; exp_r = 0; exp_w = 0;
      for (int c = 0; c < 200; c++) begin
         evt_strobe = '0;
         evt_strobe[63] = (c % 4 == 1);
         rd_txn_vld = (c % 3 != 0);
         rd_txn_id  = 16'(c * 37);
         wr_txn_vld = (c % 2 == 0);
         wr_txn_id  = 16'(c * 53 + 7);
         if (evt_strobe[63]) exp_n++;
         if (rd_txn_vld && ((rd_txn_id & 16'h00F0) == 16'h0050)) exp_r++;
         if (wr_txn_vld && ((wr_txn_id & 16'h00F0) == 16'h0050)) exp_w++;
         tick();
      end
      quiet();
      wr(4'h0, 32'h0);
      chk_reg("R2 timer ignores its selection", 4'h8, 32'd201);
      chk_reg("R7 top strobe code 0x3F", 4'h9, 32'(exp_n));
      chk_reg("R8 read filter 0x41", 4'hA, 32'(exp_r));
      chk_reg("R8 write filter 0x42", 4'hB, 32'(exp_w));

      // R10 selection change mid-run
      wr(4'h5, 32'h2);
      wr(4'h0, 32'h3);
      evt_strobe = '0; evt_strobe[2] = 1'b1;
      repeat (10) tick();
      evt_strobe[3] = 1'b1;
      wr(4'h5, 32'h3);
      evt_strobe[2] = 1'b0;
      repeat (6) tick();
      quiet();
      chk_reg("R10 switch keeps count, old code on write edge", 4'h9, 32'd17);
      chk_reg("R11 selection readback", 4'h5, 32'h3);

      // R12 disabled holds
      wr(4'h0, 32'h0);
      rd(4'h8, v);
      evt_strobe = '1; rd_txn_vld = 1'b1; wr_txn_vld = 1'b1;
      repeat (5) tick();
      quiet();
      chk_reg("R12 timer holds while disabled", 4'h8, v);
      chk_reg("R12 event counter holds while disabled", 4'h9, 32'd17);

      // R11 writes to read-only and unused addresses
      wr(4'h9, 32'hFFFF_FFFF);
      wr(4'h2, 32'hFFFF_FFFF);
      chk_reg("R11 counter write ignored", 4'h9, 32'd17);
      chk_reg("R11 unused address reads zero", 4'h2, 32'h0);
      chk_reg("R11 ctrl unchanged by other writes", 4'h0, 32'h0);

      // R3 / R4 / R5 window expiry
      wr(4'h5, 32'h0);
      wr(4'h6, 32'h1);
      wr(4'h7, 32'h40);
      wr(4'h0, 32'h3);
      for (int c = 1; c <= 300; c++) begin
         evt_strobe = '0;
         evt_strobe[0] = 1'b1;
         evt_strobe[1] = (c <= 100);
         tick();
         if (c == 255) begin
            chk_reg("R2 timer at all-ones", 4'h8, 32'hFF);
            chk("R5 no irq before window end", {31'h0, irq_o}, 32'h0);
         end
         if (c == 256) begin
            chk("R3 irq on timer wrap", {31'h0, irq_o}, 32'h1);
            chk_reg("R3 timer wraps to zero", 4'h8, 32'h0);
            chk_reg("R5 counter 1 wraps silently on final edge", 4'h9, 32'h0);
         end
      end
      quiet();
      chk_reg("R4 frozen counter 2", 4'hA, 32'd100);
      chk_reg("R4 frozen timer", 4'h8, 32'h0);
      chk_reg("R9 unknown 0x40 stays zero", 4'hB, 32'h0);
      chk_reg("R4 lock bit readable", 4'h0, 32'h5);
      chk("R4 irq held", {31'h0, irq_o}, 32'h1);

      // R6 clear after lock
      wr(4'h0, 32'h2);
      chk("R6 irq dropped by clear", {31'h0, irq_o}, 32'h0);
      chk_reg("R6 counter 2 cleared", 4'hA, 32'h0);
      chk_reg("R6 lock released", 4'h0, 32'h0);

      // R6 clear on the same edge as timer wrap
      wr(4'h0, 32'h3);
      repeat (255) tick();
      chk_reg("R2 timer at all-ones before collision", 4'h8, 32'hFF);
      wr(4'h0, 32'h3);
      chk("R6 clear beats wrap: irq low", {31'h0, irq_o}, 32'h0);
      chk_reg("R6 clear beats wrap: timer zero", 4'h8, 32'h0);
      tick();
      chk_reg("R6 counting resumes after clear", 4'h8, 32'h1);
      chk("R6 still no irq", {31'h0, irq_o}, 32'h0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule